// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Unit

This block holds the replacement state for a four-way set-associative cache and names the way to evict in any set. Each set owns three state bits arranged as a binary decision tree whose four leaves are the ways. Every node bit remembers which branch the most recent access went down: 0 for the left branch, 1 for the right one. An access marks the path to the way it touched. The candidate for eviction is found by starting at the root and always going the other way from the one each bit records.

The cache controller raises the access strobe with a set and way on every hit or fill. It reads the victim for any set through a separate query port, which is combinational on the stored state. Tag and data arrays live outside this block, and it keeps no true LRU order.

Top module: `tree_plru`

## Requirements
- R1: After reset every tree bit is 0, so the victim reported for every set is way 3.
- R2: An access to (set s, way w) sets the root bit of set s to w[1]. Root value 0 selects the pair {0,1} and root value 1 selects the pair {2,3}.
- R3: The same access sets the child bit for the pair that holds w to w[0]. The low child covers ways 0/1 and the high child covers ways 2/3; 0 means the lower-numbered way.
- R4: The child bit for the other pair in set s keeps its value through the access.
- R5: The victim is built from the inverted root bit, which forms bit 1 of the victim. Bit 0 is then the inverted low child when that root choice is the low pair, and the inverted high child otherwise.
- R6: Sets other than the accessed one do not change, and no set changes in a cycle without an access.
- R7: When an access and a query to the same set fall in the same cycle, the victim is taken from the state before that access.
- R8: In the cycle after an access, a query to that set never names the way just accessed.
- R9: Starting from reset, accesses to ways 0, 1, 2 and 3 of a set, in that order, leave way 0 as that set's victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe; updates the tree of acc_set |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | 2 | Way touched by the access |
| qry_set | input | SET_W | Set whose victim is requested |
| victim_way | output | 2 | Way to evict from qry_set |

## Verification
A wrong tree bit has no effect of its own until someone queries that set. It then shows at victim_way as the wrong way, either on the very next query or only after later accesses change which node the walk reads. A lost or misdirected update therefore stays hidden while the off-path child is not consulted. For this reason every cycle of a long mixed-access run compares the queried victim against an independent model, and targeted sequences force the walk through the child left untouched by the last access. A corrupted neighbouring set shows only when that set is queried, so the sweeps query sets other than the accessed one as well.

// File: rtl/plru_pkg.sv
package plru_pkg;

  typedef logic [1:0] way_t;

  // root: 0 = low pair {0,1}, 1 = high pair {2,3}
  // lo  : choice inside the low pair, hi: choice inside the high pair
  typedef struct packed {
    logic root;
    logic lo;
    logic hi;
  } tree_t;

  localparam int TREE_W = $bits(tree_t);

  // Mark the path toward way w as most recently used.
  function automatic tree_t tree_touch(input tree_t cur, input way_t w);
    tree_t nxt;
    nxt      = cur;
    nxt.root = w[1];
    if (w[1]) nxt.hi = w[0];
    else      nxt.lo = w[0];
    return nxt;
  endfunction

  // Walk opposite to every stored direction.
  function automatic way_t tree_pick(input tree_t cur);
    way_t v;
    v[1] = ~cur.root;
    v[0] = v[1] ? ~cur.hi : ~cur.lo;
    return v;
  endfunction

endpackage

// File: rtl/plru_set_cell.sv
module plru_set_cell
  import plru_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  touch,
  input  way_t  touch_way,
  output tree_t tree_q
);

  tree_t tree_d;

  always_comb begin
    tree_d = tree_q;
    if (touch) tree_d = tree_touch(tree_q, touch_way);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tree_q <= '0;
    else        tree_q <= tree_d;
  end

endmodule

// File: rtl/plru_victim_mux.sv
module plru_victim_mux
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 16,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic [NUM_SETS*TREE_W-1:0] tree_flat,
  input  logic [SET_W-1:0]           sel_set,
  output tree_t                      sel_tree,
  output way_t                       victim
);

  always_comb begin
    sel_tree = '0;
    for (int i = 0; i < NUM_SETS; i++) begin
      if (SET_W'(i) == sel_set) sel_tree = tree_t'(tree_flat[i*TREE_W +: TREE_W]);
    end
    victim = tree_pick(sel_tree);
  end

endmodule

// File: rtl/tree_plru.sv
module tree_plru
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 16,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic [1:0]       acc_way,
  input  logic [SET_W-1:0] qry_set,
  output logic [1:0]       victim_way
);

  logic [NUM_SETS-1:0]        touch_vec;
  logic [NUM_SETS*TREE_W-1:0] tree_flat;
  tree_t                      qry_tree;

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    tree_t cell_q;
    assign touch_vec[g] = acc_valid && (acc_set == SET_W'(g));
    plru_set_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch     (touch_vec[g]),
      .touch_way (acc_way),
      .tree_q    (cell_q)
    );
    assign tree_flat[g*TREE_W +: TREE_W] = cell_q;
  end

  plru_victim_mux #(.NUM_SETS(NUM_SETS)) u_mux (
    .tree_flat (tree_flat),
    .sel_set   (qry_set),
    .sel_tree  (qry_tree),
    .victim    (victim_way)
  );

endmodule

// File: rtl/plru_checker.sv
module plru_checker
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 16,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       acc_valid,
  input logic [SET_W-1:0]           acc_set,
  input logic [1:0]                 acc_way,
  input logic [SET_W-1:0]           qry_set,
  input logic [1:0]                 victim_way,
  input logic [NUM_SETS*TREE_W-1:0] tree_flat
);

  logic             last_valid;
  logic [SET_W-1:0] last_set;
  way_t             last_way;
  logic             prev_other;
  tree_t            cur_acc_tree;
  tree_t            last_tree;

  assign cur_acc_tree = tree_t'(tree_flat[int'(acc_set)*TREE_W +: TREE_W]);
  assign last_tree    = tree_t'(tree_flat[int'(last_set)*TREE_W +: TREE_W]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_valid <= 1'b0;
      last_set   <= '0;
      last_way   <= '0;
      prev_other <= 1'b0;
    end else begin
      last_valid <= acc_valid;
      last_set   <= acc_set;
      last_way   <= acc_way;
      prev_other <= acc_way[1] ? cur_acc_tree.lo : cur_acc_tree.hi;
    end
  end

  p_root_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_valid |-> (last_tree.root == last_way[1]));

  p_path_child_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last_valid |-> ((last_way[1] ? last_tree.hi : last_tree.lo) == last_way[0]));

  p_off_path_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_valid |-> ((last_way[1] ? last_tree.lo : last_tree.hi) == prev_other));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(tree_flat));

  p_no_fresh_victim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_valid && (qry_set == last_set)) |-> (victim_way != last_way));

endmodule

bind tree_plru plru_checker #(.NUM_SETS(NUM_SETS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_set    (acc_set),
  .acc_way    (acc_way),
  .qry_set    (qry_set),
  .victim_way (victim_way),
  .tree_flat  (tree_flat)
);

// File: tb/tree_plru_tb.sv
module tree_plru_tb;

  localparam int SETS = 4;
  localparam int SW   = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          acc_valid;
  logic [SW-1:0] acc_set;
  logic [1:0]    acc_way;
  logic [SW-1:0] qry_set;
  logic [1:0]    victim_way;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model: separate node arrays
  bit m_root [SETS];
  bit m_lo   [SETS];
  bit m_hi   [SETS];

  always #4 clk = ~clk;

  tree_plru #(.NUM_SETS(SETS)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_way(acc_way), .qry_set(qry_set), .victim_way(victim_way)
  );

  function automatic int model_victim(input int s);
    int hi_pair;
    hi_pair = m_root[s] ? 0 : 1;
    if (hi_pair == 1) return 2 + (m_hi[s] ? 0 : 1);
    else              return 0 + (m_lo[s] ? 0 : 1);
  endfunction

  task automatic model_access(input int s, input int w);
    m_root[s] = (w >= 2);
    if (w >= 2) m_hi[s] = (w % 2 == 1);
    else        m_lo[s] = (w % 2 == 1);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample before posedge, model updates at edge
  task automatic step(input bit v, input int s, input int w, input int q, input string req);
    @(negedge clk);
    acc_valid = v;
    acc_set   = SW'(s);
    acc_way   = 2'(w);
    qry_set   = SW'(q);
    #1;
    check(req, int'(victim_way), model_victim(q));
    @(posedge clk);
    if (v) model_access(s, w);
  endtask

  task automatic query(input int q, input int exp, input string req);
    @(negedge clk);
    acc_valid = 1'b0;
    qry_set   = SW'(q);
    #1;
    check(req, int'(victim_way), exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; acc_valid = 1'b0; acc_set = '0; acc_way = '0; qry_set = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < SETS; s++) begin
      m_root[s] = 0; m_lo[s] = 0; m_hi[s] = 0;
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lcg;
    do_reset();

    // R1: reset state, every set reports way 3
    for (int s = 0; s < SETS; s++) query(s, 3, "R1 reset victim");

    // R9: sequence 0,1,2,3 in set 1 leaves way 0
    for (int w = 0; w < 4; w++) step(1, 1, w, 2, "R6 other set during sequence");
    query(1, 0, "R9 victim after 0,1,2,3");
    query(2, 3, "R6 untouched set stays at reset");

    // R4: way0 then way3 in set 0; low child must still say way0 -> victim 1
    step(1, 0, 0, 0, "R7 pre-update view");
    step(1, 0, 3, 0, "R7 pre-update view");
    query(0, 1, "R4 off-path child kept");
    // R2/R3: single access then check each pair
    step(1, 3, 2, 3, "R7 pre-update view");
    query(3, 1, "R2 R3 victim after way2");
    step(1, 3, 1, 3, "R7 pre-update view");
    query(3, 3, "R5 victim walk after way1");

    // R7: same-cycle access and query returns old victim explicitly
    @(negedge clk);
    acc_valid = 1'b1; acc_set = 2'd2; acc_way = 2'd3; qry_set = 2'd2;
    #1;
    check("R7 same-cycle victim", int'(victim_way), 3);
    @(posedge clk);
    model_access(2, 3);
    query(2, 1, "R8 accessed way not victim");

    // exhaustive pairs per set: from reset, access a then b, compare victim
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        do_reset();
        step(1, a % SETS, a, a % SETS, "R7 pair step");
        step(1, a % SETS, b, a % SETS, "R7 pair step");
        query(a % SETS, model_victim(a % SETS), "R5 pair victim");
        check("R8 pair last way", (model_victim(a % SETS) != b) ? 1 : 0, 1);
      end
    end

    // long mixed sweep, idle cycles included
    do_reset();
    lcg = 12345;
    for (int n = 0; n < 3000; n++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      step(((lcg >> 4) % 4) != 0, (lcg >> 8) % SETS, (lcg >> 12) % 4,
           (lcg >> 16) % SETS, "R5 R6 sweep victim");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule